// File: doc/BRIEF.md
# Shared-Multiplier Channel Calibration Engine

This block keeps the trim state for a bank of output channels and turns raw codes into calibrated codes. Each channel holds two raw codes (bank A and bank B), a gain word, an offset word and one calibrated result per bank. One global bank bit decides where a data write lands. It also decides which of the two results a gain or offset write refreshes. A refresh computes `x*(M+1)/2^DW + C - 2^(DW-1)`, clamped to the unsigned DW-bit range.

The block has only one multiply-add unit. Any write that needs a refresh marks its (channel, bank) pair as pending. A scheduler hands the lowest pending pair to the two-stage multiply-add pipeline, one pair per clock. A write to the reserved all-ones channel number reaches every channel at once. The work it queues drains in a number of cycles that grows with the channel count.

The calibrated results cannot be written from the host port. They reach the downstream output selector through a combinational tap addressed by channel and bank. `busy` stays high while any refresh is queued or in flight.

Top module: `cal_engine`

## Requirements
- R1: After reset, every raw code is 0x8000, every gain 0xFFFF, every offset 0x8000 and the bank bit 0. Every calibrated result reads 0x8000 and `busy` is low.
- R2: A data write (`wr_sel`=0) with the bank bit at 0 stores the raw A code of that channel and refreshes its A result. Its B result is left unchanged.
- R3: A data write with the bank bit at 1 stores the raw B code and refreshes the B result only.
- R4: A gain write (`wr_sel`=1) or offset write (`wr_sel`=2) refreshes only the result of the bank selected by the bank bit.
- R5: A refreshed result equals floor(x*(M+1)/65536) + C - 32768, clamped to 0..65535 (DW=16). Here x is the raw code of that bank.
- R6: The new result shows on the tap after the second rising edge that follows the accepting edge. `busy` is high in both cycles before it and low once it shows, if nothing else is queued.
- R7: A write to channel number all-ones (63) applies to every channel and queues one refresh per channel. Refreshes are served one per cycle, so `busy` stays high for exactly NCH+1 cycles.
- R8: A write to a channel number from NCH to all-ones minus one changes no state and starts no refresh.
- R9: A control write (`wr_sel`=3) loads the bank bit from `wr_data` bit 0 and starts no refresh.
- R10: While idle with no write, the tap value for a fixed selection does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, accepted every cycle |
| wr_sel | input | 2 | 0 data, 1 gain, 2 offset, 3 bank bit |
| wr_ch | input | CW (6) | Channel number; all-ones broadcasts |
| wr_data | input | DW (16) | Write value |
| busy | output | 1 | Refresh queued or in flight |
| tap_ch | input | CW (6) | Channel for the result tap |
| tap_bank | input | 1 | Bank for the result tap (0 A, 1 B) |
| tap_data | output | DW (16) | Calibrated result; zero for an unused channel number |

## Verification
The checker watches a set of rules on every cycle. A valid refreshing write must raise `busy` on the next cycle. Control writes and writes to unused channel numbers must leave an idle block idle. Without new writes the pending count must fall by exactly one per cycle. The tap must hold still while idle. Only the bench scenarios can show the numbers: the formula and its clamps, the per-bank routing decided by the bank bit, the exact two-cycle latency, the NCH+1 cycle drain after a broadcast, and agreement with a reference model over random write mixes.

// File: rtl/cal_pkg.sv
package cal_pkg;
   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_GAIN = 2'd1,
      SEL_OFFS = 2'd2,
      SEL_CTRL = 2'd3
   } wsel_e;
endpackage

// File: rtl/cal_regbank.sv
module cal_regbank
   import cal_pkg::*;
#(
   parameter int NCH = 40,
   parameter int DW  = 16,
   parameter int CW  = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [CW-1:0] wr_ch,
   input  logic [DW-1:0] wr_data,
   output logic          bank_q,
   input  logic [CW-1:0] op_ch,
   input  logic          op_bank,
   output logic [DW-1:0] op_x,
   output logic [DW-1:0] op_m,
   output logic [DW-1:0] op_c,
   input  logic          res_we,
   input  logic [CW-1:0] res_ch,
   input  logic          res_bank,
   input  logic [DW-1:0] res_data,
   input  logic [CW-1:0] tap_ch,
   input  logic          tap_bank,
   output logic [DW-1:0] tap_data
);
   localparam logic [CW-1:0] BCAST = '1;
   localparam logic [DW-1:0] HALF  = DW'(1) << (DW - 1);
   localparam logic [DW-1:0] FULL  = '1;

   logic [DW-1:0] raw_a [NCH];
   logic [DW-1:0] raw_b [NCH];
   logic [DW-1:0] gain  [NCH];
   logic [DW-1:0] offs  [NCH];
   logic [DW-1:0] cal_a [NCH];
   logic [DW-1:0] cal_b [NCH];
   logic [NCH-1:0] hit;
   wsel_e sel;

   assign sel = wsel_e'(wr_sel);

   for (genvar g = 0; g < NCH; g++) begin : g_hit
      assign hit[g] = wr_en && (sel != SEL_CTRL) &&
                      (wr_ch == CW'(g) || wr_ch == BCAST);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bank_q <= 1'b0;
         for (int i = 0; i < NCH; i++) begin
            raw_a[i] <= HALF;
            raw_b[i] <= HALF;
            gain[i]  <= FULL;
            offs[i]  <= HALF;
            cal_a[i] <= HALF;
            cal_b[i] <= HALF;
         end
      end else begin
         if (wr_en && sel == SEL_CTRL) bank_q <= wr_data[0];
         for (int i = 0; i < NCH; i++) begin
            if (hit[i]) begin
               case (sel)
                  SEL_DATA: if (bank_q) raw_b[i] <= wr_data;
                            else        raw_a[i] <= wr_data;
                  SEL_GAIN: gain[i] <= wr_data;
                  SEL_OFFS: offs[i] <= wr_data;
                  default: ;
               endcase
            end
            if (res_we && res_ch == CW'(i)) begin
               if (res_bank) cal_b[i] <= res_data;
               else          cal_a[i] <= res_data;
            end
         end
      end
   end

   assign op_x = op_bank ? raw_b[op_ch] : raw_a[op_ch];
   assign op_m = gain[op_ch];
   assign op_c = offs[op_ch];

   assign tap_data = (tap_ch >= CW'(NCH)) ? '0 :
                     (tap_bank ? cal_b[tap_ch] : cal_a[tap_ch]);
endmodule

// File: rtl/cal_pending.sv
module cal_pending #(
   parameter int NCH = 40,
   parameter int CW  = 6,
   parameter int OW  = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          set_en,
   input  logic          set_all,
   input  logic [CW-1:0] set_ch,
   input  logic          set_bank,
   output logic          pick_valid,
   output logic [CW-1:0] pick_ch,
   output logic          pick_bank,
   output logic [OW-1:0] occ
);
   localparam int IW = CW + 1;
   localparam int NQ = 2 * NCH;

   logic [NQ-1:0] pend_q, pend_d;
   logic [IW-1:0] pick_idx;

   always_comb begin
      pick_valid = 1'b0;
      pick_idx   = '0;
      for (int i = NQ - 1; i >= 0; i--) begin
         if (pend_q[i]) begin
            pick_valid = 1'b1;
            pick_idx   = IW'(i);
         end
      end
   end

   assign pick_ch   = pick_idx[IW-1:1];
   assign pick_bank = pick_idx[0];

   always_comb begin
      pend_d = pend_q;
      if (pick_valid) pend_d[pick_idx] = 1'b0;
      for (int i = 0; i < NQ; i++) begin
         if (set_en && (set_all || set_ch == CW'(i / 2)) &&
             (set_bank == ((i % 2) == 1)))
            pend_d[i] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) pend_q <= '0;
      else     pend_q <= pend_d;
   end

   always_comb begin
      occ = '0;
      for (int i = 0; i < NQ; i++) occ = occ + OW'(pend_q[i]);
   end
endmodule

// File: rtl/cal_mac.sv
module cal_mac #(
   parameter int DW = 16,
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [CW-1:0] in_ch,
   input  logic          in_bank,
   input  logic [DW-1:0] in_x,
   input  logic [DW-1:0] in_m,
   input  logic [DW-1:0] in_c,
   output logic          out_valid,
   output logic [CW-1:0] out_ch,
   output logic          out_bank,
   output logic [DW-1:0] out_data
);
   localparam int XW = 2 * DW + 1;
   localparam int SW = DW + 3;
   localparam logic [SW-1:0] HALF = SW'(1) << (DW - 1);
   localparam logic [SW-1:0] TOP  = SW'({DW{1'b1}});

   logic [DW:0]   s1_p;
   logic [DW-1:0] s1_c;
   logic [SW-1:0] sum;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_ch    <= '0;
         out_bank  <= 1'b0;
         s1_p      <= '0;
         s1_c      <= '0;
      end else begin
         out_valid <= in_valid;
         out_ch    <= in_ch;
         out_bank  <= in_bank;
         s1_c      <= in_c;
         s1_p      <= (DW+1)'((XW'(in_x) * XW'({1'b0, in_m} + 1'b1)) >> DW);
      end
   end

   assign sum = SW'(s1_p) + SW'(s1_c) - HALF;

   always_comb begin
      if (sum[SW-1])     out_data = '0;
      else if (sum > TOP) out_data = '1;
      else               out_data = sum[DW-1:0];
   end
endmodule

// File: rtl/cal_engine.sv
module cal_engine
   import cal_pkg::*;
#(
   parameter int NCH = 40,
   parameter int DW  = 16,
   localparam int CW = $clog2(NCH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [CW-1:0] wr_ch,
   input  logic [DW-1:0] wr_data,
   output logic          busy,
   input  logic [CW-1:0] tap_ch,
   input  logic          tap_bank,
   output logic [DW-1:0] tap_data
);
   localparam int OW = $clog2(2 * NCH + 1);
   localparam logic [CW-1:0] BCAST = '1;

   if (NCH < 2) begin : g_bad_nch
      $error("cal_engine: NCH must be at least 2");
   end
   if (DW < 4 || DW > 31) begin : g_bad_dw
      $error("cal_engine: DW must lie in 4..31");
   end

   logic          bank_q;
   logic          trig;
   logic          pick_valid, pick_bank;
   logic [CW-1:0] pick_ch;
   logic [OW-1:0] q_occ;
   logic [DW-1:0] op_x, op_m, op_c;
   logic          mac_busy, res_bank;
   logic [CW-1:0] res_ch;
   logic [DW-1:0] res_data;

   assign trig = wr_en && (wsel_e'(wr_sel) != SEL_CTRL) &&
                 (wr_ch < CW'(NCH) || wr_ch == BCAST);

   cal_regbank #(.NCH(NCH), .DW(DW), .CW(CW)) u_regs (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch), .wr_data(wr_data),
      .bank_q(bank_q),
      .op_ch(pick_ch), .op_bank(pick_bank),
      .op_x(op_x), .op_m(op_m), .op_c(op_c),
      .res_we(mac_busy), .res_ch(res_ch), .res_bank(res_bank), .res_data(res_data),
      .tap_ch(tap_ch), .tap_bank(tap_bank), .tap_data(tap_data)
   );

   cal_pending #(.NCH(NCH), .CW(CW), .OW(OW)) u_pend (
      .clk(clk), .rst(rst),
      .set_en(trig), .set_all(wr_ch == BCAST), .set_ch(wr_ch), .set_bank(bank_q),
      .pick_valid(pick_valid), .pick_ch(pick_ch), .pick_bank(pick_bank),
      .occ(q_occ)
   );

   cal_mac #(.DW(DW), .CW(CW)) u_mac (
      .clk(clk), .rst(rst),
      .in_valid(pick_valid), .in_ch(pick_ch), .in_bank(pick_bank),
      .in_x(op_x), .in_m(op_m), .in_c(op_c),
      .out_valid(mac_busy), .out_ch(res_ch), .out_bank(res_bank), .out_data(res_data)
   );

   assign busy = pick_valid | mac_busy;
endmodule

// File: rtl/cal_engine_chk.sv
module cal_engine_chk #(
   parameter int NCH = 40,
   parameter int CW  = 6,
   parameter int OW  = 7,
   parameter int DW  = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          wr_en,
   input logic [1:0]    wr_sel,
   input logic [CW-1:0] wr_ch,
   input logic          busy,
   input logic [CW-1:0] tap_ch,
   input logic          tap_bank,
   input logic [DW-1:0] tap_data,
   input logic [OW-1:0] q_occ,
   input logic          mac_busy
);
   localparam logic [CW-1:0] BCAST = '1;

   assert_busy_on_trigger_R6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel != 2'd3 && (wr_ch < CW'(NCH) || wr_ch == BCAST)) |=> busy);

   assert_ctrl_no_refresh_R9: assert property (@(posedge clk) disable iff (rst)
      (!busy && wr_en && wr_sel == 2'd3) |=> !busy);

   assert_unused_ch_ignored_R8: assert property (@(posedge clk) disable iff (rst)
      (!busy && wr_en && wr_ch >= CW'(NCH) && wr_ch != BCAST) |=> !busy);

   assert_drain_one_per_cycle_R7: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && q_occ != '0) |=> (q_occ == $past(q_occ) - OW'(1)));

   assert_mac_follows_queue_R7: assert property (@(posedge clk) disable iff (rst)
      (q_occ != '0) |=> mac_busy);

   assert_tap_idle_R10: assert property (@(posedge clk) disable iff (rst)
      (!busy && !wr_en) |=>
      (!($stable(tap_ch) && $stable(tap_bank)) || $stable(tap_data)));
endmodule

bind cal_engine cal_engine_chk #(.NCH(NCH), .CW(CW), .OW(OW), .DW(DW)) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch),
   .busy(busy), .tap_ch(tap_ch), .tap_bank(tap_bank), .tap_data(tap_data),
   .q_occ(q_occ), .mac_busy(mac_busy)
);

// File: tb/tb_cal_engine.sv
module tb_cal_engine;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 40;
   localparam int DW  = 16;
   localparam int CW  = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = '0;
   logic [CW-1:0] wr_ch = '0;
   logic [DW-1:0] wr_data = '0;
   logic          busy;
   logic [CW-1:0] tap_ch = '0;
   logic          tap_bank = 1'b0;
   logic [DW-1:0] tap_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [DW-1:0] m_raw [2][NCH];
   logic [DW-1:0] m_gain [NCH];
   logic [DW-1:0] m_offs [NCH];
   logic [DW-1:0] m_cal [2][NCH];
   logic          m_bank;

   always #(CLK_PERIOD/2) clk = ~clk;

   cal_engine #(.NCH(NCH), .DW(DW)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch),
      .wr_data(wr_data), .busy(busy), .tap_ch(tap_ch), .tap_bank(tap_bank),
      .tap_data(tap_data)
   );

   function automatic logic [DW-1:0] calc(logic [DW-1:0] x, logic [DW-1:0] m, logic [DW-1:0] c);
      longint s;
      s = ((longint'(x) * (longint'(m) + 1)) >>> 16) + longint'(c) - 32768;
      if (s < 0) return '0;
      if (s > 65535) return 16'hFFFF;
      return DW'(s);
   endfunction

   task automatic check(bit ok, string tag, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic read_tap(int ch, bit bank, output logic [DW-1:0] v);
      tap_ch = CW'(ch);
      tap_bank = bank;
      #1;
      v = tap_data;
   endtask

   task automatic model_write(int sel, int ch, logic [DW-1:0] d);
      if (sel == 3) begin
         m_bank = d[0];
         return;
      end
      for (int i = 0; i < NCH; i++) begin
         if (ch == 63 || ch == i) begin
            if (sel == 0) m_raw[m_bank][i] = d;
            else if (sel == 1) m_gain[i] = d;
            else m_offs[i] = d;
            m_cal[m_bank][i] = calc(m_raw[m_bank][i], m_gain[i], m_offs[i]);
         end
      end
   endtask

   // drives at a falling edge, returns at the falling edge after the accepting edge
   task automatic do_write(int sel, int ch, logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_sel = 2'(sel);
      wr_ch = CW'(ch);
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(sel, ch, d);
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 500 && busy; k++) @(negedge clk);
   endtask

   task automatic compare_all(string tag);
      logic [DW-1:0] v;
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < NCH; i++) begin
            read_tap(i, b[0], v);
            check(v == m_cal[b][i], tag, v, m_cal[b][i]);
         end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      int cnt;
      void'($urandom(32'd20240611));
      m_bank = 1'b0;
      for (int i = 0; i < NCH; i++) begin
         m_raw[0][i] = 16'h8000; m_raw[1][i] = 16'h8000;
         m_gain[i] = 16'hFFFF;   m_offs[i] = 16'h8000;
         m_cal[0][i] = 16'h8000; m_cal[1][i] = 16'h8000;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(busy == 1'b0, "R1 busy after reset", busy, 0);
      compare_all("R1 reset results");

      // R6 and R2: latency and bank A routing
      do_write(0, 5, 16'h1234);
      read_tap(5, 0, v);
      check(busy == 1'b1, "R6 busy cycle 1", busy, 1);
      check(v == 16'h8000, "R6 old value cycle 1", v, 16'h8000);
      @(negedge clk);
      read_tap(5, 0, v);
      check(busy == 1'b1, "R6 busy cycle 2", busy, 1);
      check(v == 16'h8000, "R6 old value cycle 2", v, 16'h8000);
      @(negedge clk);
      read_tap(5, 0, v);
      check(busy == 1'b0, "R6 busy cleared", busy, 0);
      check(v == 16'h1234, "R6 R2 new A result", v, 16'h1234);
      read_tap(5, 1, v);
      check(v == 16'h8000, "R2 B result untouched", v, 16'h8000);

      // R9: bank bit write, no refresh
      do_write(3, 0, 16'h0001);
      check(busy == 1'b0, "R9 control write no refresh", busy, 0);
      // R3: data to bank B
      do_write(0, 5, 16'h4321);
      wait_idle();
      read_tap(5, 1, v);
      check(v == 16'h4321, "R3 B result", v, 16'h4321);
      read_tap(5, 0, v);
      check(v == 16'h1234, "R3 A result untouched", v, 16'h1234);

      // R4: gain write refreshes only bank B
      do_write(1, 5, 16'h7FFF);
      wait_idle();
      read_tap(5, 1, v);
      check(v == 16'h2190, "R4 gain refresh B", v, 16'h2190);
      read_tap(5, 0, v);
      check(v == 16'h1234, "R4 A not refreshed", v, 16'h1234);
      do_write(2, 5, 16'h9000);
      wait_idle();
      read_tap(5, 1, v);
      check(v == 16'h3190, "R4 offset refresh B", v, 16'h3190);
      read_tap(5, 0, v);
      check(v == 16'h1234, "R4 A not refreshed by offset", v, 16'h1234);

      // R5: clamps on channel 0, bank A
      do_write(3, 0, 16'h0000);
      do_write(0, 0, 16'h0000);
      do_write(2, 0, 16'h0000);
      wait_idle();
      read_tap(0, 0, v);
      check(v == 16'h0000, "R5 low clamp", v, 0);
      do_write(0, 0, 16'hFFFF);
      do_write(2, 0, 16'hFFFF);
      wait_idle();
      read_tap(0, 0, v);
      check(v == 16'hFFFF, "R5 high clamp", v, 16'hFFFF);
      do_write(1, 0, 16'h7FFF);
      do_write(0, 0, 16'h4000);
      do_write(2, 0, 16'h9000);
      wait_idle();
      read_tap(0, 0, v);
      check(v == 16'h3000, "R5 mid value", v, 16'h3000);

      // R8: unused channel number
      do_write(0, 50, 16'h0BAD);
      check(busy == 1'b0, "R8 unused channel no refresh", busy, 0);
      compare_all("R8 state unchanged");

      // R7: broadcast gain, drain length
      do_write(1, 63, 16'h3FFF);
      cnt = 0;
      for (int k = 0; k < 200 && busy; k++) begin
         cnt++;
         @(negedge clk);
      end
      check(cnt == NCH + 1, "R7 broadcast busy cycles", cnt, NCH + 1);
      compare_all("R7 broadcast results");

      // R10: idle tap holds
      read_tap(7, 1, v);
      repeat (3) @(negedge clk);
      check(tap_data == v, "R10 idle tap stable", tap_data, v);

      // random mix
      for (int n = 0; n < 400; n++) begin
         int sel, ch;
         logic [DW-1:0] d;
         sel = $urandom_range(3, 0);
         ch = ($urandom_range(15, 0) == 0) ? 63 : $urandom_range(47, 0);
         d = DW'($urandom);
         do_write(sel, ch, d);
         wait_idle();
         if (ch < NCH && sel != 3) begin
            read_tap(ch, m_bank, v);
            check(v == m_cal[m_bank][ch], "R5 random refresh", v, m_cal[m_bank][ch]);
         end
      end
      compare_all("R2 R3 R4 random final");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule